// File: doc/BRIEF.md
# Multiplexed Cartridge Bus Master

This block runs single-byte read and write cycles on a cartridge connector where the eight low address bits and the data byte share the same pins. A requester hands over one transfer: a 22-bit address, a write byte, a read/write flag and a target region. The block then drives the dedicated upper address lines. It puts the low address byte on the shared bus and captures it in the cartridge's external latch with a latch-enable pulse. It then runs the read or write strobe. On a read it returns the sampled byte together with a one-cycle completion pulse.

The target region is chosen with two active-low select lines that feed a NAND gate on the cartridge. With both lines high the mask ROM is enabled. Pulling select A low enables the battery-backed save SRAM. Pulling select B low enables the console CPU's built-in RAM and I/O window. Before a write to the CPU window, select A gets a short dummy pulse, so the cartridge logic sees the same edge order as in a working bank-switch write.

Every phase length is a parameter counted in clocks, so one design serves any clock rate. The default values fit a 250 MHz clock.

Top module: `cart_bus_master`

## Requirements
- R1: After reset the strobes `oe_n` and `we_n` and both selects `sel_a_n` and `sel_b_n` are high, `le` and `ad_oe` are low, and `ready` is high.
- R2: For each transfer `le` is high for exactly `T_LE` clocks. While it is high, `ad_oe` is high, `ad_out` carries address bits 7..0 and `addr_hi` carries bits 21..8. In the clock after `le` falls, `ad_out` still carries the same low byte with `ad_oe` high.
- R3: The target code selects the region. 2'b00 is ROM with both selects high, 2'b01 is SRAM with `sel_a_n` low, 2'b10 is the CPU area with `sel_b_n` low, and 2'b11 behaves exactly as ROM. The selects are never both low at once.
- R4: On reads, `ad_oe` is low in the clock before `oe_n` falls and stays low for as long as `oe_n` is low.
- R5: A read holds `oe_n` low for `T_ROM_ACC` clocks (ROM) or `T_RAM_ACC` clocks (SRAM, CPU). `rdata` is the value on `ad_in` in the last of those clocks. It is valid while `done` is high. With the defaults at 250 MHz the ROM strobe lasts at least 3000 ns.
- R6: A write holds `we_n` low for `T_WE_CPU` clocks (CPU area) or `T_WE_SRAM` clocks (other targets). During that time `ad_oe` is high and `ad_out` equals the write byte. `oe_n` stays high for the whole write. With the defaults at 250 MHz the strobes last at least 730 ns and 240 ns.
- R7: A select line only rises when `oe_n` and `we_n` were both already high in the previous clock.
- R8: A CPU-area write shows exactly one low pulse on `sel_a_n`, and that pulse ends before the latch pulse. The latch pulse happens with `sel_a_n` high and `sel_b_n` low. CPU-area reads show no pulse on `sel_a_n`.
- R9: A request is taken only while `ready` is high. `req_valid` raised while busy starts no further latch pulse and does not change the transfer in progress.
- R10: `done` is high for one clock per transfer, and `ready` is high in that same clock. A request presented in the `done` clock is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled while ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_target | input | 2 | Region: 00 ROM, 01 SRAM, 10 CPU area, 11 ROM |
| req_addr | input | 22 | Byte address |
| req_wdata | input | 8 | Write byte |
| ready | output | 1 | Block is idle and takes a request |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Read byte, valid with done |
| addr_hi | output | 14 | Address bits 21..8 on dedicated lines |
| ad_out | output | 8 | Shared bus output value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | 8 | Shared bus input value |
| le | output | 1 | Address latch enable, active high |
| oe_n | output | 1 | Cartridge output enable, active low |
| we_n | output | 1 | Cartridge write enable, active low |
| sel_a_n | output | 1 | Region select A (SRAM), active low |
| sel_b_n | output | 1 | Region select B (CPU area), active low |

## Verification
Two pairs of events can fall in the same clock. One is the completion of a transfer and the acceptance of the next one. The bench provokes it by putting a new request up in the very clock where it sees `done`. It then judges that the new transfer gets its own single latch pulse with the right address. The other pair is a busy cycle and a stray request. After each accepted request the bench holds `req_valid` high with a different random address for several clocks. A correct block shows exactly one latch pulse per transfer, latches the original address and returns the original read data.

// File: rtl/cbm_pkg.sv
// Shared types for the cartridge bus master.
// Assumes: target encoding is fixed by the requester interface.
package cbm_pkg;

    typedef enum logic [1:0] {
        TGT_ROM  = 2'b00,
        TGT_SRAM = 2'b01,
        TGT_CPU  = 2'b10,
        TGT_ALT  = 2'b11
    } cbm_target_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_DUMMY_LO,
        PH_DUMMY_HI,
        PH_SELECT,
        PH_LATCH,
        PH_HOLD,
        PH_TURN,
        PH_ACCESS,
        PH_STROBE,
        PH_RELEASE,
        PH_RECOVER
    } cbm_phase_e;

    function automatic int unsigned cbm_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cbm_phase_timer.sv
// Down-counter that times the current bus phase.
// Assumes: load_val is the phase length minus one; expired is high in the
// last clock of a phase.
module cbm_phase_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Load a new phase length or count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/cbm_sequencer.sv
// Phase sequencer: accepts a request, walks the phase order that fits the
// target and direction, and captures read data.
// Assumes: the pin driver registers its outputs, so pins lag the phase by
// one clock; read data is taken in the single RELEASE clock, while the pins
// still show the last clock of the access phase.
module cbm_sequencer
    import cbm_pkg::*;
#(
    parameter int ADDR_W    = 22,
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 10,
    parameter int T_DUMMY   = 4,
    parameter int T_SETUP   = 1,
    parameter int T_LE      = 4,
    parameter int T_SETTLE  = 4,
    parameter int T_ROM_ACC = 800,
    parameter int T_RAM_ACC = 16,
    parameter int T_WE_SRAM = 64,
    parameter int T_WE_CPU  = 184,
    parameter int T_RECOVER = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_target,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] ad_in,
    input  logic              tmr_expired,
    output cbm_phase_e        phase,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_value,
    output cbm_target_e       cur_tgt,
    output logic              cur_write,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_wdata,
    output logic              ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    cbm_phase_e  phase_q, phase_nxt;
    cbm_target_e req_tgt_norm;
    logic        accept, advance;
    logic        done_q;
    logic [DATA_W-1:0] rdata_q;

    // Length of a phase in clocks, minus one.
    function automatic logic [CNT_W-1:0] len_m1(input cbm_phase_e ph,
                                                input cbm_target_e t);
        int unsigned n;
        case (ph)
            PH_DUMMY_LO, PH_DUMMY_HI: n = T_DUMMY;
            PH_SELECT:                n = T_SETUP;
            PH_LATCH:                 n = T_LE;
            PH_HOLD:                  n = T_SETTLE;
            PH_ACCESS:                n = (t == TGT_ROM) ? T_ROM_ACC : T_RAM_ACC;
            PH_STROBE:                n = (t == TGT_CPU) ? T_WE_CPU : T_WE_SRAM;
            PH_RECOVER:               n = T_RECOVER;
            default:                  n = 1;
        endcase
        return CNT_W'(n - 1);
    endfunction

    // Fold the spare target code onto ROM.
    always_comb begin
        if (req_target == TGT_ALT) req_tgt_norm = TGT_ROM;
        else                       req_tgt_norm = cbm_target_e'(req_target);
    end

    assign ready   = (phase_q == PH_IDLE);
    assign accept  = ready && req_valid;
    assign advance = (phase_q == PH_IDLE) ? accept : tmr_expired;

    // Choose the phase that follows the current one.
    always_comb begin
        case (phase_q)
            PH_IDLE:     phase_nxt = (req_write && req_tgt_norm == TGT_CPU)
                                     ? PH_DUMMY_LO : PH_SELECT;
            PH_DUMMY_LO: phase_nxt = PH_DUMMY_HI;
            PH_DUMMY_HI: phase_nxt = PH_SELECT;
            PH_SELECT:   phase_nxt = PH_LATCH;
            PH_LATCH:    phase_nxt = PH_HOLD;
            PH_HOLD:     phase_nxt = cur_write ? PH_STROBE : PH_TURN;
            PH_TURN:     phase_nxt = PH_ACCESS;
            PH_ACCESS:   phase_nxt = PH_RELEASE;
            PH_STROBE:   phase_nxt = PH_RELEASE;
            PH_RELEASE:  phase_nxt = PH_RECOVER;
            PH_RECOVER:  phase_nxt = PH_IDLE;
            default:     phase_nxt = PH_IDLE;
        endcase
    end

    assign tmr_load  = advance;
    assign tmr_value = len_m1(phase_nxt, cur_tgt);

    // Step the phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else if (advance) phase_q <= phase_nxt;
    end

    // Hold the accepted request for the whole transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_tgt   <= TGT_ROM;
            cur_write <= 1'b0;
            cur_addr  <= '0;
            cur_wdata <= '0;
        end else if (accept) begin
            cur_tgt   <= req_tgt_norm;
            cur_write <= req_write;
            cur_addr  <= req_addr;
            cur_wdata <= req_wdata;
        end
    end

    // Capture the read byte while the pins still show the access phase.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else if (phase_q == PH_RELEASE && !cur_write) rdata_q <= ad_in;
    end

    // Raise the completion pulse in the first idle clock.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (phase_q == PH_RECOVER) && tmr_expired;
    end

    assign phase = phase_q;
    assign done  = done_q;
    assign rdata = rdata_q;
endmodule

// File: rtl/cbm_pin_driver.sv
// Registered decode of the bus phase onto the cartridge pins.
// Assumes: phase and request fields come from flops; every pin is a flop
// output so the cartridge never sees decode glitches.
module cbm_pin_driver
    import cbm_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cbm_phase_e        phase,
    input  cbm_target_e       tgt,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [HI_W-1:0]   addr_hi,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              le,
    output logic              oe_n,
    output logic              we_n,
    output logic              sel_a_n,
    output logic              sel_b_n
);
    logic              in_window;
    logic              le_d, oe_n_d, we_n_d, sa_d, sb_d, ad_oe_d;
    logic [DATA_W-1:0] ad_out_d;
    logic [HI_W-1:0]   hi_q;

    // Phases in which the region select is held.
    assign in_window = (phase == PH_SELECT) || (phase == PH_LATCH) ||
                       (phase == PH_HOLD)   || (phase == PH_TURN)  ||
                       (phase == PH_ACCESS) || (phase == PH_STROBE) ||
                       (phase == PH_RELEASE);

    // Next pin values from the current phase.
    always_comb begin
        le_d     = (phase == PH_LATCH);
        oe_n_d   = !(phase == PH_ACCESS);
        we_n_d   = !(phase == PH_STROBE);
        sa_d     = !((phase == PH_DUMMY_LO) || (in_window && tgt == TGT_SRAM));
        sb_d     = !(in_window && tgt == TGT_CPU);
        ad_oe_d  = 1'b0;
        ad_out_d = '0;
        case (phase)
            PH_SELECT, PH_LATCH, PH_HOLD: begin
                ad_oe_d  = 1'b1;
                ad_out_d = addr[DATA_W-1:0];
            end
            PH_STROBE: begin
                ad_oe_d  = 1'b1;
                ad_out_d = wdata;
            end
            PH_RELEASE: begin
                ad_oe_d  = write;
                ad_out_d = write ? wdata : '0;
            end
            default: ;
        endcase
    end

    // Register the strobes, selects and shared bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            le      <= 1'b0;
            oe_n    <= 1'b1;
            we_n    <= 1'b1;
            sel_a_n <= 1'b1;
            sel_b_n <= 1'b1;
            ad_oe   <= 1'b0;
            ad_out  <= '0;
        end else begin
            le      <= le_d;
            oe_n    <= oe_n_d;
            we_n    <= we_n_d;
            sel_a_n <= sa_d;
            sel_b_n <= sb_d;
            ad_oe   <= ad_oe_d;
            ad_out  <= ad_out_d;
        end
    end

    // Load the upper address lines when the transfer opens.
    always_ff @(posedge clk) begin
        if (!rst_n) hi_q <= '0;
        else if (phase == PH_SELECT) hi_q <= addr[ADDR_W-1:DATA_W];
    end

    assign addr_hi = hi_q;
endmodule

// File: rtl/cart_bus_master.sv
// Top of the multiplexed cartridge bus master: sequencer, phase timer and
// registered pin driver.
// Assumes: one transfer at a time; phase lengths are at least one clock.
module cart_bus_master
    import cbm_pkg::*;
#(
    parameter int ADDR_W    = 22,
    parameter int DATA_W    = 8,
    parameter int T_DUMMY   = 4,
    parameter int T_SETUP   = 1,
    parameter int T_LE      = 4,
    parameter int T_SETTLE  = 4,
    parameter int T_ROM_ACC = 800,
    parameter int T_RAM_ACC = 16,
    parameter int T_WE_SRAM = 64,
    parameter int T_WE_CPU  = 184,
    parameter int T_RECOVER = 4,
    localparam int HI_W     = ADDR_W - DATA_W,
    localparam int T_MAX    = cbm_max(cbm_max(cbm_max(T_ROM_ACC, T_RAM_ACC),
                                              cbm_max(T_WE_SRAM, T_WE_CPU)),
                                      cbm_max(cbm_max(T_DUMMY, T_SETUP),
                                              cbm_max(cbm_max(T_LE, T_SETTLE), T_RECOVER))),
    localparam int CNT_W    = $clog2(T_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_target,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [HI_W-1:0]   addr_hi,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic              le,
    output logic              oe_n,
    output logic              we_n,
    output logic              sel_a_n,
    output logic              sel_b_n
);
    cbm_phase_e        phase;
    cbm_target_e       cur_tgt;
    logic              cur_write;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;
    logic              tmr_load, tmr_expired;
    logic [CNT_W-1:0]  tmr_value;

    cbm_sequencer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .T_DUMMY(T_DUMMY), .T_SETUP(T_SETUP), .T_LE(T_LE),
        .T_SETTLE(T_SETTLE), .T_ROM_ACC(T_ROM_ACC), .T_RAM_ACC(T_RAM_ACC),
        .T_WE_SRAM(T_WE_SRAM), .T_WE_CPU(T_WE_CPU), .T_RECOVER(T_RECOVER)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_target(req_target),
        .req_addr(req_addr), .req_wdata(req_wdata), .ad_in(ad_in),
        .tmr_expired(tmr_expired), .phase(phase),
        .tmr_load(tmr_load), .tmr_value(tmr_value),
        .cur_tgt(cur_tgt), .cur_write(cur_write),
        .cur_addr(cur_addr), .cur_wdata(cur_wdata),
        .ready(ready), .done(done), .rdata(rdata)
    );

    cbm_phase_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .load(tmr_load), .load_val(tmr_value), .expired(tmr_expired)
    );

    cbm_pin_driver #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk(clk), .rst_n(rst_n),
        .phase(phase), .tgt(cur_tgt), .write(cur_write),
        .addr(cur_addr), .wdata(cur_wdata),
        .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .le(le),
        .oe_n(oe_n), .we_n(we_n), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n)
    );
endmodule

// File: rtl/cbm_checker.sv
// Protocol checker for the cartridge bus pins, bound to cart_bus_master.
// Assumes: only top-level ports are observed.
module cbm_checker (
    input logic clk,
    input logic rst_n,
    input logic ready,
    input logic done,
    input logic ad_oe,
    input logic le,
    input logic oe_n,
    input logic we_n,
    input logic sel_a_n,
    input logic sel_b_n
);
    assert_latch_drives_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        le |-> ad_oe);

    assert_selects_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_a_n || sel_b_n);

    assert_no_contention_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !ad_oe);

    assert_turnaround_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_n) |-> $past(!ad_oe));

    assert_write_drives_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (ad_oe && oe_n));

    assert_sel_a_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_a_n) |-> $past(oe_n && we_n));

    assert_sel_b_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_b_n) |-> $past(oe_n && we_n));

    assert_idle_while_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (oe_n && we_n && !le));

    assert_done_with_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ready);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind cart_bus_master cbm_checker u_cbm_checker (
    .clk(clk), .rst_n(rst_n), .ready(ready), .done(done), .ad_oe(ad_oe),
    .le(le), .oe_n(oe_n), .we_n(we_n), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n)
);

// File: tb/cart_bus_master_test.sv
`timescale 1ns/1ps
module cart_bus_master_test;
    localparam int CLK_NS    = 4;
    localparam int T_LE      = 4;
    localparam int T_ROM_ACC = 800;
    localparam int T_RAM_ACC = 16;
    localparam int T_WE_SRAM = 64;
    localparam int T_WE_CPU  = 184;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_target = 2'b00;
    logic [21:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready, done, ad_oe, le, oe_n, we_n, sel_a_n, sel_b_n;
    logic [7:0]  rdata, ad_out, ad_in;
    logic [13:0] addr_hi;

    int checks = 0, fails = 0;

    cart_bus_master uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_target(req_target), .req_addr(req_addr), .req_wdata(req_wdata),
        .ready(ready), .done(done), .rdata(rdata), .addr_hi(addr_hi),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .le(le), .oe_n(oe_n),
        .we_n(we_n), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n)
    );

    always #(CLK_NS/2) clk = ~clk;

    // ---- cartridge model and monitor ----
    logic [7:0]  lat_lo = '0;
    logic [13:0] lat_hi = '0;
    int le_cnt, le_rises, oe_cnt, we_cnt, sa_falls;
    logic [7:0] we_data;
    logic sa_at_le, sb_at_le, bad_le, hold_bad, contention, turn_bad, we_bad, rel_bad;
    logic p_le = 0, p_oe_n = 1, p_we_n = 1, p_sa = 1, p_sb = 1, p_ad_oe = 0;

    function automatic logic [7:0] rd_model(input logic [1:0] t, input logic [21:0] a);
        return a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]} ^ {t, 6'h15};
    endfunction

    function automatic logic [1:0] norm_tgt(input logic [1:0] t);
        return (t == 2'b11) ? 2'b00 : t;
    endfunction

    assign ad_in = !oe_n ? rd_model(!sel_a_n ? 2'b01 : (!sel_b_n ? 2'b10 : 2'b00),
                                     {lat_hi, lat_lo}) : 8'h00;

    task automatic clear_mon();
        le_cnt = 0; le_rises = 0; oe_cnt = 0; we_cnt = 0; sa_falls = 0;
        we_data = '0; sa_at_le = 1; sb_at_le = 1; bad_le = 0; hold_bad = 0;
        contention = 0; turn_bad = 0; we_bad = 0; rel_bad = 0;
    endtask

    initial clear_mon();

    always @(negedge clk) begin
        if (rst_n) begin
            if (le) begin
                le_cnt++; lat_lo = ad_out; lat_hi = addr_hi;
                sa_at_le = sel_a_n; sb_at_le = sel_b_n;
                if (!ad_oe) bad_le = 1;
                if (!p_le) le_rises++;
            end
            if (p_le && !le && !(ad_oe && ad_out == lat_lo)) hold_bad = 1;
            if (!oe_n) begin
                oe_cnt++;
                if (ad_oe) contention = 1;
                if (p_oe_n && p_ad_oe) turn_bad = 1;
            end
            if (!we_n) begin
                we_cnt++; we_data = ad_out;
                if (!ad_oe || !oe_n) we_bad = 1;
            end
            if (!sel_a_n && p_sa) sa_falls++;
            if (((sel_a_n && !p_sa) || (sel_b_n && !p_sb)) && !(p_oe_n && p_we_n)) rel_bad = 1;
        end
        p_le = le; p_oe_n = oe_n; p_we_n = we_n; p_sa = sel_a_n; p_sb = sel_b_n; p_ad_oe = ad_oe;
    end

    // ---- checking helpers ----
    task automatic check(input string req, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    endtask

    // Issue one transfer; optionally stray requests while busy; check it.
    task automatic run_txn(input logic wr, input logic [1:0] tgt, input logic [21:0] a,
                           input logic [7:0] wd, input logic stray, input logic already_at_done);
        logic [1:0] nt;
        int wait_cyc;
        nt = norm_tgt(tgt);
        if (!already_at_done) begin
            wait_cyc = 0;
            while (!ready && wait_cyc < 5000) begin @(negedge clk); wait_cyc++; end
        end
        clear_mon();
        req_write = wr; req_target = tgt; req_addr = a; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (stray) begin
            req_valid = 1'b1; req_addr = a ^ 22'h2A5A5A; req_write = ~wr;
            req_target = tgt ^ 2'b01; req_wdata = ~wd;
            for (int k = 0; k < 5; k++) @(negedge clk);
            req_valid = 1'b0;
        end
        wait_cyc = 0;
        while (!done && wait_cyc < 5000) begin @(negedge clk); wait_cyc++; end
        check("R10 done seen", done, done, 1);
        check("R10 ready with done", ready, ready, 1);
        check("R2 one latch pulse / R9 stray ignored", le_rises == 1, le_rises, 1);
        check("R2 latch width", le_cnt == T_LE, le_cnt, T_LE);
        check("R2 latched address", {lat_hi, lat_lo} == a, {lat_hi, lat_lo}, a);
        check("R2 bus driven and held", !bad_le && !hold_bad, hold_bad, 0);
        check("R3 select B at latch", sb_at_le == (nt != 2'b10), sb_at_le, nt != 2'b10);
        check("R7 select release order", !rel_bad, rel_bad, 0);
        if (wr) begin
            check("R6 write strobe width", we_cnt == ((nt == 2'b10) ? T_WE_CPU : T_WE_SRAM),
                  we_cnt, (nt == 2'b10) ? T_WE_CPU : T_WE_SRAM);
            check("R6 write min ns", we_cnt * CLK_NS >= ((nt == 2'b10) ? 730 : 240),
                  we_cnt * CLK_NS, (nt == 2'b10) ? 730 : 240);
            check("R6 write data", we_data == wd && !we_bad, we_data, wd);
            check("R6 no read strobe", oe_cnt == 0, oe_cnt, 0);
        end else begin
            check("R5 read strobe width", oe_cnt == ((nt == 2'b00) ? T_ROM_ACC : T_RAM_ACC),
                  oe_cnt, (nt == 2'b00) ? T_ROM_ACC : T_RAM_ACC);
            if (nt == 2'b00) check("R5 rom min ns", oe_cnt * CLK_NS >= 3000, oe_cnt * CLK_NS, 3000);
            check("R5 read data", rdata == rd_model(nt, a), rdata, rd_model(nt, a));
            check("R4 turnaround", !contention && !turn_bad, turn_bad, 0);
            check("R5 no write strobe", we_cnt == 0, we_cnt, 0);
        end
        if (nt == 2'b10 && wr) begin
            check("R8 dummy pulse count", sa_falls == 1, sa_falls, 1);
            check("R8 sel A high at latch", sa_at_le, sa_at_le, 1);
        end else begin
            check("R3 sel A falls", sa_falls == ((nt == 2'b01) ? 1 : 0), sa_falls, nt == 2'b01);
            check("R3 sel A at latch", sa_at_le == (nt != 2'b01), sa_at_le, nt != 2'b01);
        end
    endtask

    // Watchdog.
    initial begin
        #(150000 * CLK_NS);
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h00C0FFEE);
        repeat (3) @(negedge clk);
        check("R1 reset strobes", oe_n && we_n && !le, {oe_n, we_n, le}, 3'b110);
        check("R1 reset selects", sel_a_n && sel_b_n, {sel_a_n, sel_b_n}, 2'b11);
        check("R1 reset ready/bus", ready && !ad_oe && !done, {ready, ad_oe, done}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", ready && oe_n && we_n && sel_a_n && sel_b_n,
              {ready, oe_n, we_n}, 3'b111);

        // Directed corners.
        run_txn(1'b0, 2'b00, 22'h000000, 8'h00, 1'b0, 1'b0);   // R5 ROM at zero
        run_txn(1'b0, 2'b11, 22'h3FFFFF, 8'h00, 1'b0, 1'b0);   // R3 spare code = ROM
        run_txn(1'b1, 2'b01, 22'h007FFF, 8'hA5, 1'b0, 1'b0);   // R6 SRAM write
        run_txn(1'b1, 2'b10, 22'h00FFFF, 8'h28, 1'b0, 1'b0);   // R8 CPU write
        run_txn(1'b0, 2'b10, 22'h00FEC0, 8'h00, 1'b1, 1'b0);   // R8 CPU read, R9 stray
        run_txn(1'b0, 2'b01, 22'h001234, 8'h00, 1'b0, 1'b0);
        // R10 back-to-back: next request in the done clock.
        run_txn(1'b0, 2'b01, 22'h00ABCD, 8'h00, 1'b0, 1'b1);
        @(negedge clk);
        check("R10 done one clock", !done, done, 0);

        // Random mix, with stray requests while busy (R9).
        for (int i = 0; i < 36; i++) begin
            logic [1:0] t;
            logic w;
            t = 2'($urandom);
            w = 1'($urandom);
            if (t == 2'b00 && !w && ($urandom % 2) == 0) t = 2'b01;
            run_txn(w, t, 22'($urandom), 8'($urandom), 1'($urandom), 1'b0);
        end
        finish_run();
    end
endmodule